// File: doc/BRIEF.md
# Dual-Pixel Scanout Frame Buffer Arbiter

This block shares one 64-bit frame memory among three users: a video scanner, an image warper port and a host port. The memory is two 32-bit banks that are accessed together, so each read returns two adjacent pixels. Each pixel is a 32-bit word. It carries red in bits 23:16, green in bits 15:8 and blue in bits 7:0.

The block also generates raster timing for 800x600 at 60 Hz from a 40 MHz pixel clock. Horizontally a line has 800 active pixels, a 40-pixel front porch, a 128-pixel sync pulse and 1056 pixels in total. Vertically a frame has 600 active lines, a 1-line front porch, a 4-line sync pulse, a 23-line back porch and 628 lines in total.

The memory slot alternates with the parity of the horizontal count. Even cycles belong to the scanner, which fetches one word one pair ahead of display into a two-pixel shift register. Odd cycles go to the warper or the host, with the warper first. Because the scanner only needs every other cycle, the clients can never delay the picture. The memory has a synchronous read with one cycle of latency.

Top module: `fb_scan_arbiter`

## Requirements
- R1: While rst_ni is low, blank_o is 1, hsync_o and vsync_o are 0, and neither client grant is asserted.
- R2: Each line lasts H_TOTAL cycles. hsync_o is high, active high, exactly while the horizontal count is in [H_ACTIVE+H_FP, H_ACTIVE+H_FP+H_SYNC). The count is 0 at the first active pixel.
- R3: Each frame lasts V_TOTAL lines. vsync_o is high, active high, exactly while the line count is in [V_ACTIVE+V_FP, V_ACTIVE+V_FP+V_SYNC). vsync_o changes only at horizontal count 0.
- R4: blank_o is 1 outside the H_ACTIVE x V_ACTIVE region and 0 inside it. pix_o is 0 whenever blank_o is 1.
- R5: Pixels are scanned left to right and top to bottom. At active position (x, y), pix_o equals bits 31:0 of memory word y*(H_ACTIVE/2)+x/2 when x is even, and bits 63:32 of that word when x is odd.
- R6: The scanner issues a read (mem_we_o=0) only in cycles with an even horizontal count. It fetches word y*(H_ACTIVE/2)+x/2 two cycles before pixel x of line y is shown, with the count wrapping across the line and frame boundary. Client grants occur only in cycles with an odd horizontal count.
- R7: In an odd cycle, a pending warper request is granted. A host request is granted only when the warper is not requesting. A request stays pending until it is granted.
- R8: In a granted cycle, the client's write enable, address and write data appear on the memory port. A word written during vertical blanking is shown in the next frame.
- R9: One cycle after a granted read, the granted client sees rvalid high and rdata equal to the addressed word. rvalid is low at all other times.
- R10: Pixel output stays correct while both clients request on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wrp_req_i | input | 1 | Warper request, held until granted |
| wrp_we_i | input | 1 | Warper write enable |
| wrp_addr_i | input | ADDR_W | Warper word address |
| wrp_wdata_i | input | 2*PIX_W | Warper write data |
| wrp_gnt_o | output | 1 | Warper granted this cycle |
| wrp_rvalid_o | output | 1 | Warper read data valid |
| wrp_rdata_o | output | 2*PIX_W | Warper read data |
| host_req_i | input | 1 | Host request, held until granted |
| host_we_i | input | 1 | Host write enable |
| host_addr_i | input | ADDR_W | Host word address |
| host_wdata_i | input | 2*PIX_W | Host write data |
| host_gnt_o | output | 1 | Host granted this cycle |
| host_rvalid_o | output | 1 | Host read data valid |
| host_rdata_o | output | 2*PIX_W | Host read data |
| mem_en_o | output | 1 | Memory access enable |
| mem_we_o | output | 1 | Memory write enable |
| mem_addr_o | output | ADDR_W | Memory word address |
| mem_wdata_o | output | 2*PIX_W | Memory write data |
| mem_rdata_i | input | 2*PIX_W | Memory read data, one cycle after the access |
| pix_o | output | PIX_W | Current pixel, zero while blanked |
| hsync_o | output | 1 | Horizontal sync, active high |
| vsync_o | output | 1 | Vertical sync, active high |
| blank_o | output | 1 | Blanking indicator |

## Verification
Scanout and client service run in the same cycles. A scanner fetch in one cycle is followed by a client grant in the next, and read data for both returns on the shared memory bus one cycle behind. The bench provokes this by running both clients continuously on a shrunken raster: the warper streams writes and the host streams reads, which also forces priority collisions. It then compares every active pixel against memory contents computed from the bench's own coordinates. A slot overlap or a data mix-up shows up either as a wrong pixel, or as client read data that differs from the word the bench recorded at grant time.

// File: rtl/fb_scan_pkg.sv
package fb_scan_pkg;
  localparam int PIX_W  = 32;
  localparam int WORD_W = 2 * PIX_W;

  typedef enum logic {
    SLOT_SCAN   = 1'b0,
    SLOT_CLIENT = 1'b1
  } slot_e;
endpackage

// File: rtl/fb_timing_gen.sv
module fb_timing_gen #(
  parameter int H_ACTIVE = 800,
  parameter int H_FP     = 40,
  parameter int H_SYNC   = 128,
  parameter int H_TOTAL  = 1056,
  parameter int V_ACTIVE = 600,
  parameter int V_FP     = 1,
  parameter int V_SYNC   = 4,
  parameter int V_TOTAL  = 628
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  output logic                hsync_o,
  output logic                vsync_o,
  output logic                blank_o,
  output logic                fetch_o,
  output logic                fetch_first_o,
  output fb_scan_pkg::slot_e  slot_o
);
  import fb_scan_pkg::*;

  localparam int HW = $clog2(H_TOTAL);
  localparam int VW = $clog2(V_TOTAL);
  localparam logic [HW-1:0] H_LAST = HW'(H_TOTAL - 1);
  localparam logic [HW-1:0] H_PRE  = HW'(H_TOTAL - 2);
  localparam logic [HW-1:0] H_ACT  = HW'(H_ACTIVE);
  localparam logic [HW-1:0] HS_B   = HW'(H_ACTIVE + H_FP);
  localparam logic [HW-1:0] HS_E   = HW'(H_ACTIVE + H_FP + H_SYNC);
  localparam logic [VW-1:0] V_LAST = VW'(V_TOTAL - 1);
  localparam logic [VW-1:0] V_ACT  = VW'(V_ACTIVE);
  localparam logic [VW-1:0] VS_B   = VW'(V_ACTIVE + V_FP);
  localparam logic [VW-1:0] VS_E   = VW'(V_ACTIVE + V_FP + V_SYNC);

  logic [HW-1:0] h_q, nh;
  logic [VW-1:0] v_q, nv;

  // reset two pixels before frame origin so the first word is prefetched
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      h_q <= H_PRE;
      v_q <= V_LAST;
    end else if (h_q == H_LAST) begin
      h_q <= '0;
      v_q <= (v_q == V_LAST) ? '0 : v_q + 1'b1;
    end else begin
      h_q <= h_q + 1'b1;
    end
  end

  // position shown two cycles from now
  always_comb begin
    nh = h_q + HW'(2);
    nv = v_q;
    if (h_q == H_PRE) begin
      nh = '0;
      nv = (v_q == V_LAST) ? '0 : v_q + 1'b1;
    end
  end

  assign hsync_o       = (h_q >= HS_B) && (h_q < HS_E);
  assign vsync_o       = (v_q >= VS_B) && (v_q < VS_E);
  assign blank_o       = !((h_q < H_ACT) && (v_q < V_ACT));
  assign slot_o        = h_q[0] ? SLOT_CLIENT : SLOT_SCAN;
  assign fetch_o       = !h_q[0] && (nh < H_ACT) && (nv < V_ACT);
  assign fetch_first_o = (nh == '0) && (nv == '0);

  p_line_wrap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (h_q == H_LAST) |=> (h_q == '0));
  p_vsync_line_start_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(vsync_o) |-> (h_q == '0));
endmodule

// File: rtl/fb_slot_arbiter.sv
module fb_slot_arbiter (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  fb_scan_pkg::slot_e slot_i,
  input  logic               wrp_req_i,
  input  logic               host_req_i,
  output logic               wrp_gnt_o,
  output logic               host_gnt_o
);
  import fb_scan_pkg::*;

  logic open_slot;
  assign open_slot  = (slot_i == SLOT_CLIENT);
  assign wrp_gnt_o  = open_slot && wrp_req_i;
  assign host_gnt_o = open_slot && host_req_i && !wrp_req_i;

  p_one_grant_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({wrp_gnt_o, host_gnt_o}));
  p_grant_odd_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wrp_gnt_o || host_gnt_o) |-> (slot_i == SLOT_CLIENT));
  p_host_yields_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_gnt_o |-> !wrp_req_i);
endmodule

// File: rtl/fb_pixel_shifter.sv
module fb_pixel_shifter #(
  parameter int PIX_W = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [2*PIX_W-1:0] word_i,
  input  logic               shift_i,
  output logic [PIX_W-1:0]   pix_o
);
  logic [2*PIX_W-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sr_q <= '0;
    else if (load_i)  sr_q <= word_i;
    else if (shift_i) sr_q <= {{PIX_W{1'b0}}, sr_q[2*PIX_W-1:PIX_W]};
  end

  assign pix_o = sr_q[PIX_W-1:0];

  // load lands after a scan slot, shift at the end of one: never together
  p_load_shift_apart_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(load_i && shift_i));
endmodule

// File: rtl/fb_scan_arbiter.sv
module fb_scan_arbiter #(
  parameter int H_ACTIVE = 800,
  parameter int H_FP     = 40,
  parameter int H_SYNC   = 128,
  parameter int H_TOTAL  = 1056,
  parameter int V_ACTIVE = 600,
  parameter int V_FP     = 1,
  parameter int V_SYNC   = 4,
  parameter int V_TOTAL  = 628,
  parameter int ADDR_W   = 18
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            wrp_req_i,
  input  logic                            wrp_we_i,
  input  logic [ADDR_W-1:0]               wrp_addr_i,
  input  logic [fb_scan_pkg::WORD_W-1:0]  wrp_wdata_i,
  output logic                            wrp_gnt_o,
  output logic                            wrp_rvalid_o,
  output logic [fb_scan_pkg::WORD_W-1:0]  wrp_rdata_o,
  input  logic                            host_req_i,
  input  logic                            host_we_i,
  input  logic [ADDR_W-1:0]               host_addr_i,
  input  logic [fb_scan_pkg::WORD_W-1:0]  host_wdata_i,
  output logic                            host_gnt_o,
  output logic                            host_rvalid_o,
  output logic [fb_scan_pkg::WORD_W-1:0]  host_rdata_o,
  output logic                            mem_en_o,
  output logic                            mem_we_o,
  output logic [ADDR_W-1:0]               mem_addr_o,
  output logic [fb_scan_pkg::WORD_W-1:0]  mem_wdata_o,
  input  logic [fb_scan_pkg::WORD_W-1:0]  mem_rdata_i,
  output logic [fb_scan_pkg::PIX_W-1:0]   pix_o,
  output logic                            hsync_o,
  output logic                            vsync_o,
  output logic                            blank_o
);
  import fb_scan_pkg::*;

  slot_e             slot;
  logic              fetch, fetch_first, fetch_q;
  logic [ADDR_W-1:0] scan_addr_q, scan_addr;
  logic [PIX_W-1:0]  sr_pix;

  fb_timing_gen #(
    .H_ACTIVE(H_ACTIVE), .H_FP(H_FP), .H_SYNC(H_SYNC), .H_TOTAL(H_TOTAL),
    .V_ACTIVE(V_ACTIVE), .V_FP(V_FP), .V_SYNC(V_SYNC), .V_TOTAL(V_TOTAL)
  ) u_timing (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .hsync_o(hsync_o), .vsync_o(vsync_o), .blank_o(blank_o),
    .fetch_o(fetch), .fetch_first_o(fetch_first), .slot_o(slot)
  );

  fb_slot_arbiter u_arb (
    .clk_i(clk_i), .rst_ni(rst_ni), .slot_i(slot),
    .wrp_req_i(wrp_req_i), .host_req_i(host_req_i),
    .wrp_gnt_o(wrp_gnt_o), .host_gnt_o(host_gnt_o)
  );

  fb_pixel_shifter #(.PIX_W(PIX_W)) u_shift (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .load_i(fetch_q), .word_i(mem_rdata_i),
    .shift_i(slot == SLOT_SCAN), .pix_o(sr_pix)
  );

  assign scan_addr = fetch_first ? '0 : scan_addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fetch_q       <= 1'b0;
      scan_addr_q   <= '0;
      wrp_rvalid_o  <= 1'b0;
      host_rvalid_o <= 1'b0;
    end else begin
      fetch_q       <= fetch;
      wrp_rvalid_o  <= wrp_gnt_o && !wrp_we_i;
      host_rvalid_o <= host_gnt_o && !host_we_i;
      if (fetch) scan_addr_q <= scan_addr + 1'b1;
    end
  end

  always_comb begin
    mem_en_o    = fetch || wrp_gnt_o || host_gnt_o;
    mem_we_o    = 1'b0;
    mem_addr_o  = scan_addr;
    mem_wdata_o = '0;
    if (wrp_gnt_o) begin
      mem_we_o    = wrp_we_i;
      mem_addr_o  = wrp_addr_i;
      mem_wdata_o = wrp_wdata_i;
    end else if (host_gnt_o) begin
      mem_we_o    = host_we_i;
      mem_addr_o  = host_addr_i;
      mem_wdata_o = host_wdata_i;
    end
  end

  assign wrp_rdata_o  = mem_rdata_i;
  assign host_rdata_o = mem_rdata_i;
  assign pix_o        = blank_o ? '0 : sr_pix;

  p_scan_read_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch |-> (mem_en_o && !mem_we_o && !wrp_gnt_o && !host_gnt_o));
  p_host_rvalid_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_rvalid_o |-> $past(host_gnt_o && !host_we_i));
  p_wrp_rvalid_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrp_rvalid_o |-> $past(wrp_gnt_o && !wrp_we_i));
  p_blank_dark_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blank_o |-> (pix_o == '0));
endmodule

// File: tb/fb_scan_arbiter_bench.sv
module fb_scan_arbiter_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HA = 8, HF = 2, HS = 3, HT = 16;
  localparam int VA = 4, VF = 1, VS = 1, VT = 8;
  localparam int AW = 6;
  localparam int MW = 1 << AW;

  logic clk = 0, rst_n = 0;
  logic wrp_req = 0, wrp_we = 0, host_req = 0, host_we = 0;
  logic [AW-1:0] wrp_addr = '0, host_addr = '0;
  logic [63:0] wrp_wdata = '0, host_wdata = '0;
  logic wrp_gnt, wrp_rvalid, host_gnt, host_rvalid;
  logic [63:0] wrp_rdata, host_rdata;
  logic mem_en, mem_we;
  logic [AW-1:0] mem_addr;
  logic [63:0] mem_wdata, mem_rdata;
  logic [31:0] pix;
  logic hsync, vsync, blank;

  int checks = 0, errors = 0;
  bit done = 0;
  int eh, ev;
  logic [63:0] mem [MW];
  bit rd_pend = 0;
  logic [63:0] rd_exp;

  always #(CLK_PERIOD/2) clk = ~clk;

  fb_scan_arbiter #(
    .H_ACTIVE(HA), .H_FP(HF), .H_SYNC(HS), .H_TOTAL(HT),
    .V_ACTIVE(VA), .V_FP(VF), .V_SYNC(VS), .V_TOTAL(VT), .ADDR_W(AW)
  ) u_fb_scan_arbiter (
    .clk_i(clk), .rst_ni(rst_n),
    .wrp_req_i(wrp_req), .wrp_we_i(wrp_we), .wrp_addr_i(wrp_addr), .wrp_wdata_i(wrp_wdata),
    .wrp_gnt_o(wrp_gnt), .wrp_rvalid_o(wrp_rvalid), .wrp_rdata_o(wrp_rdata),
    .host_req_i(host_req), .host_we_i(host_we), .host_addr_i(host_addr), .host_wdata_i(host_wdata),
    .host_gnt_o(host_gnt), .host_rvalid_o(host_rvalid), .host_rdata_o(host_rdata),
    .mem_en_o(mem_en), .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_rdata_i(mem_rdata),
    .pix_o(pix), .hsync_o(hsync), .vsync_o(vsync), .blank_o(blank)
  );

  initial begin
    for (int i = 0; i < MW; i++)
      mem[i] = {32'hA000_0000 | 32'(2*i+1), 32'hA000_0000 | 32'(2*i)};
  end

  // synchronous-read memory model
  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) mem[mem_addr] <= mem_wdata;
      mem_rdata <= mem[mem_addr];
    end
  end

  // bench raster position, starts two pixels before the frame origin
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eh <= HT - 2; ev <= VT - 1;
    end else if (eh == HT - 1) begin
      eh <= 0; ev <= (ev == VT - 1) ? 0 : ev + 1;
    end else eh <= eh + 1;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h (h=%0d v=%0d)", req, act, exp, eh, ev);
    end
  endtask

  // per-cycle monitor
  always @(negedge clk) begin
    if (rst_n) begin
      int nh, nv, w;
      bit act, even;
      act  = (eh < HA) && (ev < VA);
      even = (eh % 2) == 0;
      chk(hsync == ((eh >= HA+HF) && (eh < HA+HF+HS)), "R2 hsync", 64'(hsync), 64'((eh >= HA+HF) && (eh < HA+HF+HS)));
      chk(vsync == ((ev >= VA+VF) && (ev < VA+VF+VS)), "R3 vsync", 64'(vsync), 64'((ev >= VA+VF) && (ev < VA+VF+VS)));
      chk(blank == !act, "R4 blank", 64'(blank), 64'(!act));
      if (!act) chk(pix == 32'h0, "R4 dark pixel", 64'(pix), 64'h0);
      else begin
        w = ev*(HA/2) + eh/2;
        chk(pix == ((eh % 2) ? mem[w][63:32] : mem[w][31:0]), "R5/R10 pixel", 64'(pix),
            64'((eh % 2) ? mem[w][63:32] : mem[w][31:0]));
      end
      // scanner fetch expectation
      nh = eh + 2; nv = ev;
      if (eh == HT - 2) begin nh = 0; nv = (ev == VT - 1) ? 0 : ev + 1; end
      if (even) begin
        chk(!wrp_gnt && !host_gnt, "R6 no grant in scan slot", 64'({wrp_gnt, host_gnt}), 64'h0);
        if (nh < HA && nv < VA) begin
          w = nv*(HA/2) + nh/2;
          chk(mem_en && !mem_we && mem_addr == AW'(w), "R6 scan fetch", {mem_en, mem_we, 56'(mem_addr)}, {2'b10, 56'(w)});
        end
      end else begin
        chk(wrp_gnt == wrp_req, "R7 warper grant", 64'(wrp_gnt), 64'(wrp_req));
        chk(host_gnt == (host_req && !wrp_req), "R7 host grant", 64'(host_gnt), 64'(host_req && !wrp_req));
      end
      if (wrp_gnt)
        chk(mem_en && mem_we == wrp_we && mem_addr == wrp_addr && mem_wdata == wrp_wdata,
            "R8 forward", mem_wdata, wrp_wdata);
      // read return
      chk(host_rvalid == rd_pend, "R9 host rvalid", 64'(host_rvalid), 64'(rd_pend));
      if (rd_pend && host_rvalid) chk(host_rdata == rd_exp, "R9 host rdata", host_rdata, rd_exp);
      chk(!wrp_rvalid, "R9 warper rvalid", 64'(wrp_rvalid), 64'h0);
      rd_pend = host_gnt && !host_we;
      if (rd_pend) rd_exp = mem[host_addr];
    end
  end

  task automatic wrp_write(input logic [AW-1:0] a, input logic [63:0] d);
    @(posedge clk); #1;
    wrp_req = 1; wrp_we = 1; wrp_addr = a; wrp_wdata = d;
    @(negedge clk);
    while (!wrp_gnt) @(negedge clk);
    @(posedge clk); #1;
    wrp_req = 0; wrp_we = 0;
  endtask

  task automatic host_read(input logic [AW-1:0] a);
    @(posedge clk); #1;
    host_req = 1; host_we = 0; host_addr = a;
    @(negedge clk);
    while (!host_gnt) @(negedge clk);
    @(posedge clk); #1;
    host_req = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R1: reset state, with requests raised
    repeat (2) @(negedge clk);
    wrp_req = 1; host_req = 1;
    #1;
    chk(blank && !hsync && !vsync, "R1 reset outputs", {61'h0, blank, hsync, vsync}, 64'h4);
    chk(!wrp_gnt && !host_gnt, "R1 reset grants", 64'({wrp_gnt, host_gnt}), 64'h0);
    @(negedge clk); #1;
    chk(!wrp_gnt && !host_gnt, "R1 reset grants", 64'({wrp_gnt, host_gnt}), 64'h0);
    wrp_req = 0; host_req = 0;
    @(negedge clk); rst_n = 1;

    // R10: both clients busy while scanout continues
    fork
      begin
        for (int n = 0; n < 40; n++) begin
          wrp_write(AW'(16 + n % 48), {32'(n), 32'hC0DE_0000 | 32'(n)});
          repeat (n % 3) @(posedge clk);
        end
      end
      begin
        for (int n = 0; n < 60; n++) host_read(AW'((n * 7) % MW));
      end
    join

    // R8: frame write during vertical blanking shows in the next frame
    @(negedge clk);
    while (ev != VA) @(negedge clk);
    wrp_write(AW'(5), 64'hDEAD_BEEF_0BAD_F00D);
    host_read(AW'(5));
    repeat (2 * HT * VT) @(posedge clk);
    @(negedge clk);
    chk(mem[5] == 64'hDEAD_BEEF_0BAD_F00D, "R8 stored word", mem[5], 64'hDEAD_BEEF_0BAD_F00D);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule